// File: doc/BRIEF.md
# Flash Busy-Status Read Responder

This block produces the word returned on a parallel flash read port while an internal program or erase job may be running. It remembers whether a job is in flight, which kind of job it is, and the data word that was loaded for programming. Array storage and the timing of the job itself live elsewhere. A start pulse opens a job and a completion pulse closes it.

Each rising edge of the read strobe is one read access. When no job is running, the access returns the array word presented alongside the strobe. While a job runs, the access returns a status word instead. That word carries two independent completion indicators. A polling bit reads back the inverse of the loaded data while programming, and 0 while erasing. A toggle bit flips on every access. Software can watch either indicator until true data comes back.

Top module: `flash_busy_responder`

## Requirements
- R1: After a synchronous active-low reset, `rd_valid` is 0, `rd_data` is 0 and no job is in flight, so the first access returns array data.
- R2: One cycle after the cycle in which a strobe rising edge is sampled, `rd_valid` is high for exactly one cycle. When no job is in flight, `rd_data` then equals the `array_data` sampled with the edge on all 16 bits.
- R3: While a program job (`op_kind` = 2'b00) is in flight, bit 7 of every access is the inverse of bit 7 of the data loaded with the start pulse.
- R4: While an erase job is in flight, bit 7 of every access is 0. Chip erase is `op_kind` = 2'b01, sector erase is 2'b10, and 2'b11 is also treated as erase.
- R5: While any job is in flight, bit 6 takes the opposite value on each successive access. The bit-6 state is 0 after reset and is kept between jobs.
- R6: While a job is in flight, bits 15..8 and 5..0 return the loaded data for a program job and 0 for an erase job. The `array_data` value is ignored.
- R7: The bit-6 state changes only on a strobe rising edge. A strobe held high for several cycles counts as one access and produces one `rd_valid` pulse.
- R8: If `op_done` and a strobe edge fall in the same cycle, that access already returns true array data and bit 6 does not flip.
- R9: An access whose edge is sampled in the cycle right after the `op_start` pulse already returns the status word. If `op_start` and `op_done` coincide, the new job is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_start | input | 1 | One-cycle pulse opening a job |
| op_kind | input | 2 | Job kind: 00 program, 01 chip erase, 10 sector erase |
| op_data | input | 16 | Data word loaded for programming, captured on `op_start` |
| op_done | input | 1 | One-cycle pulse closing the job |
| rd_strobe | input | 1 | Read strobe; each rising edge is one access |
| array_data | input | 16 | True array word for the current access |
| rd_data | output | 16 | Returned read word |
| rd_valid | output | 1 | High for one cycle when `rd_data` holds a new access result |

## Verification
A completion pulse and a read access can land in the same cycle. In that case the read must see the job already closed. The bench provokes this by raising `op_done` on the same falling clock edge that raises the strobe. The scoreboard expects plain array data for that access. A later access then shows that bit 6 did not flip, and one more access confirms no status word reappears.

// File: rtl/fsr_pkg.sv
// Package: shared job-kind encoding for the flash busy-status responder.
// Assumes: any kind other than program is handled as an erase.
package fsr_pkg;
    typedef enum logic [1:0] {
        OP_PROG       = 2'b00,
        OP_CHIP_ERASE = 2'b01,
        OP_SECT_ERASE = 2'b10,
        OP_RSVD       = 2'b11
    } op_kind_e;
endpackage

// File: rtl/fsr_strobe_edge.sv
// Module: detects the rising edge of the read strobe; one edge is one access.
// Assumes: the strobe is synchronous to clk.
module fsr_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic rd_evt_o
);
    logic strobe_q;

    // Remember the previous strobe level.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe_i;
    end

    assign rd_evt_o = strobe_i & ~strobe_q;

    // R7
    no_double_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_evt_o |=> !rd_evt_o);
endmodule

// File: rtl/fsr_op_tracker.sv
// Module: tracks whether a job is in flight, its kind and the loaded data.
// Assumes: start and done are one-cycle pulses. A done pulse hides busy from a
// same-cycle read. Start wins over a coincident done.
module fsr_op_tracker
    import fsr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        kind_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              done_i,
    output logic              busy_eff_o,
    output logic              is_prog_o,
    output logic [DATA_W-1:0] loaded_o
);
    logic              busy_q;
    op_kind_e          kind_q;
    logic [DATA_W-1:0] loaded_q;

    // Busy flag: set by start, cleared by done.
    always_ff @(posedge clk) begin
        if (!rst_n)       busy_q <= 1'b0;
        else if (start_i) busy_q <= 1'b1;
        else if (done_i)  busy_q <= 1'b0;
    end

    // Capture the job kind and the loaded word on start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q   <= OP_PROG;
            loaded_q <= '0;
        end else if (start_i) begin
            kind_q   <= op_kind_e'(kind_i);
            loaded_q <= data_i;
        end
    end

    assign busy_eff_o = busy_q & ~done_i;
    assign is_prog_o  = (kind_q == OP_PROG);
    assign loaded_o   = loaded_q;

    // R9
    start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_eff_o || done_i);
    // R8
    done_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !start_i) |=> !busy_q);
endmodule

// File: rtl/fsr_toggle.sv
// Module: bit-6 toggle state, which flips once per access while busy.
// Assumes: rd_evt is a single-cycle access indication.
module fsr_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_evt_i,
    input  logic busy_eff_i,
    output logic tog_o
);
    logic tog_q;

    // Flip on a busy access, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                       tog_q <= 1'b0;
        else if (rd_evt_i && busy_eff_i)  tog_q <= ~tog_q;
    end

    assign tog_o = tog_q;

    // R7
    tog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_evt_i && busy_eff_i) |=> $stable(tog_q));
    // R5
    tog_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_evt_i && busy_eff_i) |=> tog_q != $past(tog_q));
endmodule

// File: rtl/fsr_status_mux.sv
// Module: builds the returned word (array data or status) and registers it.
// Assumes: the toggle state given is the value before this access flips it.
module fsr_status_mux #(
    parameter int DATA_W     = 16,
    parameter int POLL_BIT   = 7,
    parameter int TOGGLE_BIT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_evt_i,
    input  logic              busy_eff_i,
    input  logic              is_prog_i,
    input  logic [DATA_W-1:0] loaded_i,
    input  logic              tog_i,
    input  logic [DATA_W-1:0] array_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_valid_o
);
    localparam int TOP_BIT = DATA_W - 1;

    logic [DATA_W-1:0] status_w;
    logic [DATA_W-1:0] word_w;

    // Compose the status word and choose between it and array data.
    always_comb begin
        status_w             = is_prog_i ? loaded_i : '0;
        status_w[POLL_BIT]   = is_prog_i ? ~loaded_i[POLL_BIT] : 1'b0;
        status_w[TOGGLE_BIT] = tog_i;
        word_w               = busy_eff_i ? status_w : array_i;
    end

    // Register the result of each access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_o  <= '0;
            rd_valid_o <= 1'b0;
        end else begin
            rd_valid_o <= rd_evt_i;
            if (rd_evt_i) rd_data_o <= word_w;
        end
    end

    // R2
    idle_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_evt_i && !busy_eff_i) |=> rd_data_o == $past(array_i));
    // R3
    prog_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_evt_i && busy_eff_i && is_prog_i) |=> rd_data_o[POLL_BIT] != $past(loaded_i[POLL_BIT]));
    // R4
    erase_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_evt_i && busy_eff_i && !is_prog_i) |=> rd_data_o[POLL_BIT] == 1'b0);
    // R6
    erase_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_evt_i && busy_eff_i && !is_prog_i) |=> rd_data_o[TOP_BIT] == 1'b0);
    // R2
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |=> !rd_valid_o);
endmodule

// File: rtl/flash_busy_responder.sv
// Module: top of the flash busy-status read responder.
// Assumes: all inputs are synchronous to clk; reset is synchronous, active low.
module flash_busy_responder #(
    parameter int DATA_W     = 16,
    parameter int POLL_BIT   = 7,
    parameter int TOGGLE_BIT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  logic [1:0]        op_kind,
    input  logic [DATA_W-1:0] op_data,
    input  logic              op_done,
    input  logic              rd_strobe,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic              rd_evt;
    logic              busy_eff;
    logic              is_prog;
    logic [DATA_W-1:0] loaded;
    logic              tog;

    fsr_strobe_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (rd_strobe),
        .rd_evt_o (rd_evt)
    );

    fsr_op_tracker #(.DATA_W(DATA_W)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (op_start),
        .kind_i     (op_kind),
        .data_i     (op_data),
        .done_i     (op_done),
        .busy_eff_o (busy_eff),
        .is_prog_o  (is_prog),
        .loaded_o   (loaded)
    );

    fsr_toggle u_tog (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_evt_i   (rd_evt),
        .busy_eff_i (busy_eff),
        .tog_o      (tog)
    );

    fsr_status_mux #(
        .DATA_W     (DATA_W),
        .POLL_BIT   (POLL_BIT),
        .TOGGLE_BIT (TOGGLE_BIT)
    ) u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_evt_i   (rd_evt),
        .busy_eff_i (busy_eff),
        .is_prog_i  (is_prog),
        .loaded_i   (loaded),
        .tog_i      (tog),
        .array_i    (array_data),
        .rd_data_o  (rd_data),
        .rd_valid_o (rd_valid)
    );
endmodule

// File: tb/flash_busy_responder_test.sv
module flash_busy_responder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_start = 1'b0;
    logic [1:0]  op_kind = 2'b00;
    logic [15:0] op_data = '0;
    logic        op_done = 1'b0;
    logic        rd_strobe = 1'b0;
    logic [15:0] array_data = '0;
    logic [15:0] rd_data;
    logic        rd_valid;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 0;

    // bench model state
    bit          m_busy = 0;
    bit          m_prog = 1;
    logic [15:0] m_loaded = '0;
    bit          m_tog = 0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    flash_busy_responder uut (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
        .op_data(op_data), .op_done(op_done), .rd_strobe(rd_strobe),
        .array_data(array_data), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] expect_word(input logic [15:0] arr);
        logic [15:0] w;
        if (!m_busy) return arr;
        w = m_prog ? m_loaded : 16'h0000;
        w[7] = m_prog ? ~m_loaded[7] : 1'b0;
        w[6] = m_tog;
        return w;
    endfunction

    // driver: one access, strobe held for 'hold' cycles; optional same-cycle done
    task automatic do_read(input logic [15:0] arr, input int hold, input bit with_done, input string tag);
        @(negedge clk);
        rd_strobe = 1'b1;
        array_data = arr;
        if (with_done) begin
            op_done = 1'b1;
            m_busy = 0;
        end
        exp_q.push_back(expect_word(arr));
        tag_q.push_back(tag);
        if (m_busy) m_tog = ~m_tog;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            op_done = 1'b0;
            array_data = ~arr;
        end
        rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic start_op(input logic [1:0] kind, input logic [15:0] d);
        @(negedge clk);
        op_start = 1'b1; op_kind = kind; op_data = d;
        @(negedge clk);
        op_start = 1'b0;
        m_busy = 1; m_prog = (kind == 2'b00); m_loaded = d;
    endtask

    task automatic finish_op();
        @(negedge clk);
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0;
        m_busy = 0;
    endtask

    // monitor: pop and compare each produced result
    always @(negedge clk) begin
        if (rst_n && rd_valid && !finished) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected rd_valid", rd_data, 16'h0000);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rd_data === e, t, rd_data, e);
            end
        end
    end

    task automatic summary();
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            check(1'b0, "watchdog", 16'h0, 16'h0);
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(rd_valid === 1'b0, "R1 rd_valid after reset", {15'h0, rd_valid}, 16'h0);
        check(rd_data === 16'h0, "R1 rd_data after reset", rd_data, 16'h0);
        do_read(16'hBEEF, 1, 0, "R1 first read is array data");
        // R2: idle pass-through, several patterns
        do_read(16'h5A5A, 1, 0, "R2 idle read 5A5A");
        do_read(16'hFFC0, 1, 0, "R2 idle read FFC0");
        // R9/R3/R6: program with bit7=1, read right after start
        @(negedge clk);
        op_start = 1'b1; op_kind = 2'b00; op_data = 16'hA5C3;
        m_busy = 1; m_prog = 1; m_loaded = 16'hA5C3;
        @(negedge clk);
        op_start = 1'b0;
        rd_strobe = 1'b1; array_data = 16'h1111;
        exp_q.push_back(expect_word(16'h1111)); tag_q.push_back("R9 R3 R6 first read after start");
        m_tog = ~m_tog;
        @(negedge clk);
        rd_strobe = 1'b0;
        @(negedge clk);
        do_read(16'h2222, 1, 0, "R5 second busy read toggles");
        // R7: held strobe is one access
        do_read(16'h3333, 4, 0, "R7 held strobe single access");
        do_read(16'h4444, 1, 0, "R7 toggle flipped once");
        finish_op();
        do_read(16'h0F0F, 1, 0, "R2 true data after done");
        do_read(16'hF0F0, 1, 0, "R5 toggle stopped after done");
        // R3: program with bit7=0
        start_op(2'b00, 16'h1234);
        do_read(16'hAAAA, 1, 0, "R3 poll bit inverted 0->1");
        do_read(16'hAAAA, 1, 0, "R5 R6 program bits");
        finish_op();
        // R4/R6: chip erase
        start_op(2'b01, 16'hFFFF);
        do_read(16'hFFFF, 1, 0, "R4 chip erase poll 0");
        do_read(16'hFFFF, 1, 0, "R6 chip erase other bits 0");
        finish_op();
        // R4: sector erase; R8 done coinciding with read
        start_op(2'b10, 16'h8080);
        do_read(16'h7777, 1, 0, "R4 sector erase poll 0");
        do_read(16'hC3C3, 1, 1, "R8 done same cycle gives array data");
        do_read(16'h9999, 1, 0, "R8 no status after done");
        // R4: reserved kind treated as erase; R9 start+done coincide keeps busy
        @(negedge clk);
        op_start = 1'b1; op_done = 1'b1; op_kind = 2'b11; op_data = 16'hFFFF;
        @(negedge clk);
        op_start = 1'b0; op_done = 1'b0;
        m_busy = 1; m_prog = 0; m_loaded = 16'hFFFF;
        do_read(16'hFFFF, 1, 0, "R9 R4 start wins over done, kind 11 erase");
        finish_op();
        do_read(16'h6E6E, 1, 0, "R2 final idle read");
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R2 all accesses answered", 16'(exp_q.size()), 16'h0);
        summary();
    end
endmodule